// File: doc/BRIEF.md
# IO Rail Deep Power-Down Controller

This block parks groups of pad supply rails in a deep power-down state and brings them back, under control of a small register file on an APB-style bus. Sixty rails are split into two banks of thirty. Software writes one request word per bank. The low bits of the word mark the rails to act on, and a two-bit command in the top bits says whether those rails enter or leave power-down. The controller drives a per-rail power-down line at once. It then waits a programmable number of bus-clock cycles for the pads to settle, and only then copies each selected rail's acknowledge into a status register that software can poll.

A global sample-enable bit gates all request handling. A request that arrives while a settling window is still open is parked in a single holding slot and started after the window closes.

Top module: `io_rail_dpd_ctrl`

## Requirements
- R1: After reset every rail power-down output is 0, both status registers read 0, both request registers read 0 (command idle), and sampling is disabled.
- R2: Registers sit at byte offsets 0x020 (sample enable, bit 0), 0x1B8 / 0x1BC (bank 0 request / status), 0x1C0 / 0x1C4 (bank 1 request / status) and 0x1C8 (settling count). Request, sample and count registers read back what was last written.
- R3: In a request word, bits 29:0 select rails and bits 31:30 carry the command: 1 means leave power-down (output driven 0) and 2 means enter power-down (output driven 1). Bank 0 bit k is rail k, and bank 1 bit k is rail 30+k. The outputs of selected rails change on the clock edge that accepts the request.
- R4: A status bit changes only when the settling window of an operation that selected that rail closes. The window is N clock edges after acceptance, where N is the settling count. With a healthy rail, enter leaves the bit at 1 and leave leaves it at 0.
- R5: Command codes 0 and 3 change no output and no status bit. Rails that a request does not select keep their output and status.
- R6: While sample enable is 0, request writes are stored but start no operation, and a parked request is discarded.
- R7: A request accepted while a window is open is parked and is started on the edge after that window closes. A further request that arrives while the slot is full is dropped.
- R8: Bits 31:30 of a status register always read 0.
- R9: At window close each selected status bit takes that rail's acknowledge input, so a rail that fails to acknowledge shows a status that differs from the command.
- R10: A settling count of 0 behaves as a count of 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus and controller clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| psel | input | 1 | Bus select |
| penable | input | 1 | Bus access phase |
| pwrite | input | 1 | 1 = write, 0 = read |
| paddr | input | 12 | Byte address |
| pwdata | input | 32 | Write data |
| prdata | output | 32 | Read data (valid in the same cycle) |
| rail_dpd_o | output | 60 | Per-rail power-down command, 1 = powered down |
| rail_ack_i | input | 60 | Per-rail acknowledge, 1 = rail reports powered down |

## Verification
The hard case is a new request write that lands on the same edge as the close of a running window. Here the status update, the parking decision and the release of an already parked request all interact. The bench provokes this by issuing back-to-back request writes with settling counts of 0 to 4, so that the second write falls before, on and after the closing edge. A behavioural model with a queue for the holding slot predicts every rail output on every clock and every status read. The model is the judge, and it tells apart a request that was started late, started early or dropped.

// File: rtl/dpd_pkg.sv
package dpd_pkg;
    localparam logic [11:0] ADDR_SAMPLE = 12'h020;
    localparam logic [11:0] ADDR_REQ0   = 12'h1B8;
    localparam logic [11:0] ADDR_STAT0  = 12'h1BC;
    localparam logic [11:0] ADDR_TIMER  = 12'h1C8;
    localparam int          BANK_STRIDE = 8;
    localparam int          CODE_LSB    = 30;

    typedef enum logic [1:0] {
        CMD_IDLE  = 2'd0,
        CMD_WAKE  = 2'd1,
        CMD_SLEEP = 2'd2,
        CMD_RSVD  = 2'd3
    } dpd_cmd_e;
endpackage

// File: rtl/dpd_settle_timer.sv
module dpd_settle_timer #(
    parameter int TIMER_W = 16
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               start_i,
    input  logic [TIMER_W-1:0] period_i,
    output logic               busy_o,
    output logic               done_o,
    output logic [TIMER_W-1:0] cnt_o
);
    localparam logic [TIMER_W-1:0] ONE = {{(TIMER_W-1){1'b0}}, 1'b1};

    typedef struct packed {
        logic               busy;
        logic [TIMER_W-1:0] cnt;
    } tmr_t;

    tmr_t q, d;

    always_comb begin
        d = q;
        if (q.busy) begin
            d.cnt = q.cnt - ONE;
            if (q.cnt == ONE) d.busy = 1'b0;
        end
        if (start_i) begin
            d.busy = 1'b1;
            d.cnt  = (period_i == '0) ? ONE : period_i;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign busy_o = q.busy;
    assign done_o = q.busy && (q.cnt == ONE);
    assign cnt_o  = q.cnt;
endmodule

// File: rtl/dpd_apb_regs.sv
module dpd_apb_regs
    import dpd_pkg::*;
#(
    parameter int BANK_RAILS = 30,
    parameter int NUM_BANKS  = 2,
    parameter int TIMER_W    = 16,
    localparam int NUM_RAILS = BANK_RAILS * NUM_BANKS
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 psel,
    input  logic                 penable,
    input  logic                 pwrite,
    input  logic [11:0]          paddr,
    input  logic [31:0]          pwdata,
    output logic [31:0]          prdata,
    input  logic [NUM_RAILS-1:0] status_i,
    output logic                 sample_en_o,
    output logic [TIMER_W-1:0]   timer_o,
    output logic                 req_v_o,
    output logic                 req_enter_o,
    output logic [NUM_RAILS-1:0] req_mask_o
);
    typedef struct packed {
        logic                                 en;
        logic [TIMER_W-1:0]                   timer;
        logic [NUM_BANKS-1:0][1:0]            code;
        logic [NUM_BANKS-1:0][BANK_RAILS-1:0] sel;
    } regs_t;

    regs_t q, d;
    logic  wr;
    logic [1:0] wcode;
    logic [NUM_BANKS-1:0] hit_req;
    logic [NUM_BANKS-1:0] hit_stat;

    assign wr    = psel & penable & pwrite;
    assign wcode = pwdata[CODE_LSB +: 2];

    for (genvar b = 0; b < NUM_BANKS; b++) begin : g_dec
        assign hit_req[b]  = (paddr == ADDR_REQ0  + 12'(BANK_STRIDE * b));
        assign hit_stat[b] = (paddr == ADDR_STAT0 + 12'(BANK_STRIDE * b));
    end

    always_comb begin
        d           = q;
        req_v_o     = 1'b0;
        req_enter_o = 1'b0;
        req_mask_o  = '0;
        if (wr) begin
            if (paddr == ADDR_SAMPLE) d.en    = pwdata[0];
            if (paddr == ADDR_TIMER)  d.timer = pwdata[TIMER_W-1:0];
            for (int b = 0; b < NUM_BANKS; b++) begin
                if (hit_req[b]) begin
                    d.code[b] = wcode;
                    d.sel[b]  = pwdata[BANK_RAILS-1:0];
                    if (q.en && (wcode == CMD_WAKE || wcode == CMD_SLEEP)) begin
                        req_v_o     = 1'b1;
                        req_enter_o = (wcode == CMD_SLEEP);
                        req_mask_o[b*BANK_RAILS +: BANK_RAILS] = pwdata[BANK_RAILS-1:0];
                    end
                end
            end
        end
    end

    always_comb begin
        prdata = '0;
        if (paddr == ADDR_SAMPLE) prdata[0] = q.en;
        if (paddr == ADDR_TIMER)  prdata[TIMER_W-1:0] = q.timer;
        for (int b = 0; b < NUM_BANKS; b++) begin
            if (hit_req[b]) begin
                prdata[CODE_LSB +: 2]      = q.code[b];
                prdata[BANK_RAILS-1:0]     = q.sel[b];
            end
            if (hit_stat[b]) prdata[BANK_RAILS-1:0] = status_i[b*BANK_RAILS +: BANK_RAILS];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign sample_en_o = q.en;
    assign timer_o     = q.timer;
endmodule

// File: rtl/dpd_sequencer.sv
module dpd_sequencer #(
    parameter int NUM_RAILS = 60
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 sample_en_i,
    input  logic                 req_v_i,
    input  logic                 req_enter_i,
    input  logic [NUM_RAILS-1:0] req_mask_i,
    input  logic                 tmr_busy_i,
    input  logic                 tmr_done_i,
    input  logic [NUM_RAILS-1:0] rail_ack_i,
    output logic                 launch_o,
    output logic [NUM_RAILS-1:0] rail_dpd_o,
    output logic [NUM_RAILS-1:0] status_o
);
    typedef struct packed {
        logic [NUM_RAILS-1:0] mask;
        logic                 hold_v;
        logic                 hold_enter;
        logic [NUM_RAILS-1:0] hold_mask;
        logic [NUM_RAILS-1:0] dpd;
        logic [NUM_RAILS-1:0] stat;
    } seq_t;

    seq_t q, d;
    logic                 launch;
    logic                 l_enter;
    logic [NUM_RAILS-1:0] l_mask;

    always_comb begin
        d       = q;
        launch  = 1'b0;
        l_enter = 1'b0;
        l_mask  = '0;
        if (tmr_done_i) d.stat = (q.stat & ~q.mask) | (rail_ack_i & q.mask);
        if (tmr_busy_i) begin
            if (req_v_i && !q.hold_v) begin
                d.hold_v     = 1'b1;
                d.hold_enter = req_enter_i;
                d.hold_mask  = req_mask_i;
            end
        end else if (q.hold_v) begin
            d.hold_v = 1'b0;
            launch   = sample_en_i;
            l_enter  = q.hold_enter;
            l_mask   = q.hold_mask;
            if (req_v_i) begin
                d.hold_v     = 1'b1;
                d.hold_enter = req_enter_i;
                d.hold_mask  = req_mask_i;
            end
        end else if (req_v_i) begin
            launch  = 1'b1;
            l_enter = req_enter_i;
            l_mask  = req_mask_i;
        end
        if (launch) begin
            d.mask = l_mask;
            d.dpd  = l_enter ? (q.dpd | l_mask) : (q.dpd & ~l_mask);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign launch_o   = launch;
    assign rail_dpd_o = q.dpd;
    assign status_o   = q.stat;
endmodule

// File: rtl/io_rail_dpd_ctrl.sv
module io_rail_dpd_ctrl #(
    parameter int BANK_RAILS = 30,
    parameter int NUM_BANKS  = 2,
    parameter int TIMER_W    = 16,
    localparam int NUM_RAILS = BANK_RAILS * NUM_BANKS
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 psel,
    input  logic                 penable,
    input  logic                 pwrite,
    input  logic [11:0]          paddr,
    input  logic [31:0]          pwdata,
    output logic [31:0]          prdata,
    output logic [NUM_RAILS-1:0] rail_dpd_o,
    input  logic [NUM_RAILS-1:0] rail_ack_i
);
    logic                 sample_en;
    logic [TIMER_W-1:0]   timer_val;
    logic                 req_v;
    logic                 req_enter;
    logic [NUM_RAILS-1:0] req_mask;
    logic [NUM_RAILS-1:0] status;
    logic                 launch;
    logic                 tmr_busy;
    logic                 tmr_done;
    logic [TIMER_W-1:0]   tmr_cnt;

    dpd_apb_regs #(
        .BANK_RAILS(BANK_RAILS), .NUM_BANKS(NUM_BANKS), .TIMER_W(TIMER_W)
    ) u_regs (
        .clk(clk), .rst_n(rst_n), .psel(psel), .penable(penable), .pwrite(pwrite),
        .paddr(paddr), .pwdata(pwdata), .prdata(prdata), .status_i(status),
        .sample_en_o(sample_en), .timer_o(timer_val), .req_v_o(req_v),
        .req_enter_o(req_enter), .req_mask_o(req_mask)
    );

    dpd_settle_timer #(.TIMER_W(TIMER_W)) u_timer (
        .clk(clk), .rst_n(rst_n), .start_i(launch), .period_i(timer_val),
        .busy_o(tmr_busy), .done_o(tmr_done), .cnt_o(tmr_cnt)
    );

    dpd_sequencer #(.NUM_RAILS(NUM_RAILS)) u_seq (
        .clk(clk), .rst_n(rst_n), .sample_en_i(sample_en), .req_v_i(req_v),
        .req_enter_i(req_enter), .req_mask_i(req_mask), .tmr_busy_i(tmr_busy),
        .tmr_done_i(tmr_done), .rail_ack_i(rail_ack_i), .launch_o(launch),
        .rail_dpd_o(rail_dpd_o), .status_o(status)
    );
endmodule

// File: rtl/dpd_ctrl_chk.sv
module dpd_ctrl_chk
    import dpd_pkg::*;
#(
    parameter int NUM_RAILS = 60,
    parameter int TIMER_W   = 16
) (
    input logic                 clk,
    input logic                 rst_n,
    input logic                 psel,
    input logic                 pwrite,
    input logic [11:0]          paddr,
    input logic [31:0]          prdata,
    input logic                 launch,
    input logic                 tmr_busy,
    input logic                 tmr_done,
    input logic [TIMER_W-1:0]   tmr_cnt,
    input logic [NUM_RAILS-1:0] rail_dpd,
    input logic [NUM_RAILS-1:0] status
);
    AST_DPD_ONLY_ON_LAUNCH: assert property (@(posedge clk) disable iff (!rst_n) !$stable(rail_dpd) |-> $past(launch)); // R3
    AST_STAT_ONLY_ON_CLOSE: assert property (@(posedge clk) disable iff (!rst_n) !$stable(status) |-> $past(tmr_done)); // R4
    AST_LAUNCH_OPENS_WINDOW: assert property (@(posedge clk) disable iff (!rst_n) launch |=> tmr_busy); // R4
    AST_NO_LAUNCH_WHILE_OPEN: assert property (@(posedge clk) disable iff (!rst_n) launch |-> !tmr_busy); // R7
    AST_STAT_TOP_BITS_ZERO: assert property (@(posedge clk) disable iff (!rst_n) (psel && !pwrite && paddr == ADDR_STAT0) |-> prdata[31:30] == 2'b00); // R8
    AST_OPEN_COUNT_NONZERO: assert property (@(posedge clk) disable iff (!rst_n) tmr_busy |-> tmr_cnt != '0); // R10
endmodule

bind io_rail_dpd_ctrl dpd_ctrl_chk #(.NUM_RAILS(NUM_RAILS), .TIMER_W(TIMER_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .psel(psel), .pwrite(pwrite), .paddr(paddr),
    .prdata(prdata), .launch(launch), .tmr_busy(tmr_busy), .tmr_done(tmr_done),
    .tmr_cnt(tmr_cnt), .rail_dpd(rail_dpd_o), .status(status)
);

// File: tb/io_rail_dpd_ctrl_test.sv
`timescale 1ns/1ps
module io_rail_dpd_ctrl_test;
    localparam int NR = 60;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          psel = 1'b0, penable = 1'b0, pwrite = 1'b0;
    logic [11:0]   paddr = '0;
    logic [31:0]   pwdata = '0;
    logic [31:0]   prdata;
    logic [NR-1:0] rail_dpd;
    logic [NR-1:0] ack_q = '0;
    logic [NR-1:0] stuck = '0;

    int  vectors = 0;
    int  miscompares = 0;
    bit  finished = 1'b0;

    always #2 clk = ~clk;

    io_rail_dpd_ctrl uut (
        .clk(clk), .rst_n(rst_n), .psel(psel), .penable(penable), .pwrite(pwrite),
        .paddr(paddr), .pwdata(pwdata), .prdata(prdata),
        .rail_dpd_o(rail_dpd), .rail_ack_i(ack_q)
    );

    // simple rail model: acknowledges its command half a cycle later unless stuck
    always @(negedge clk) ack_q <= rail_dpd & ~stuck;

    // ---------------- behavioural reference model ----------------
    bit            m_en;
    int            m_timer;
    logic [31:0]   m_req0, m_req1;
    logic [NR-1:0] m_dpd, m_stat, m_mask;
    bit            m_busy;
    int            m_cnt;
    logic [NR-1:0] hq_m[$];
    bit            hq_e[$];
    bit            wv, we, he;
    logic [NR-1:0] wm, hm;

    task automatic m_start(input bit e, input logic [NR-1:0] mk);
        m_busy = 1'b1;
        m_cnt  = (m_timer == 0) ? 1 : m_timer;
        m_mask = mk;
        if (e) m_dpd = m_dpd | mk;
        else   m_dpd = m_dpd & ~mk;
    endtask

    always @(posedge clk) begin
        if (!rst_n) begin
            m_en = 0; m_timer = 0; m_req0 = 0; m_req1 = 0;
            m_dpd = 0; m_stat = 0; m_mask = 0; m_busy = 0; m_cnt = 0;
            hq_m.delete(); hq_e.delete();
        end else begin
            wv = psel && penable && pwrite && (paddr == 12'h1B8 || paddr == 12'h1C0)
                 && m_en && (pwdata[31:30] == 2'd1 || pwdata[31:30] == 2'd2);
            we = (pwdata[31:30] == 2'd2);
            wm = NR'(pwdata[29:0]) << ((paddr == 12'h1C0) ? 30 : 0);
            if (m_busy) begin
                if (m_cnt == 1) begin
                    m_busy = 0;
                    m_stat = (m_stat & ~m_mask) | (ack_q & m_mask);
                end else m_cnt = m_cnt - 1;
                if (wv && hq_m.size() == 0) begin hq_m.push_back(wm); hq_e.push_back(we); end
            end else if (hq_m.size() != 0) begin
                hm = hq_m.pop_front();
                he = hq_e.pop_front();
                if (m_en) m_start(he, hm);
                if (wv) begin hq_m.push_back(wm); hq_e.push_back(we); end
            end else if (wv) m_start(we, wm);
            if (psel && penable && pwrite) begin
                case (paddr)
                    12'h020: m_en = pwdata[0];
                    12'h1C8: m_timer = int'(pwdata[15:0]);
                    12'h1B8: m_req0 = pwdata;
                    12'h1C0: m_req1 = pwdata;
                    default: ;
                endcase
            end
        end
    end

    function automatic logic [31:0] m_read(input logic [11:0] a);
        case (a)
            12'h020: return {31'd0, m_en};
            12'h1C8: return 32'(m_timer);
            12'h1B8: return m_req0;
            12'h1C0: return m_req1;
            12'h1BC: return {2'b00, m_stat[29:0]};
            12'h1C4: return {2'b00, m_stat[59:30]};
            default: return 32'd0;
        endcase
    endfunction

    task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
        vectors++;
        if (!ok) begin
            miscompares++;
            $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
        end
    endtask

    // every-clock comparison of rail commands (R3)
    always @(negedge clk) begin
        if (rst_n && !finished) chk(rail_dpd === m_dpd, "R3 rail outputs", 64'(rail_dpd), 64'(m_dpd));
    end

    task automatic wr(input logic [11:0] a, input logic [31:0] v);
        @(negedge clk); psel = 1; penable = 0; pwrite = 1; paddr = a; pwdata = v;
        @(negedge clk); penable = 1;
        @(negedge clk); psel = 0; penable = 0; pwrite = 0;
    endtask

    // use_k = 1 compares against the constant k, else against the model
    task automatic rd(input logic [11:0] a, input string tag, input bit use_k, input logic [31:0] k);
        logic [31:0] e;
        @(negedge clk); psel = 1; penable = 0; pwrite = 0; paddr = a;
        @(negedge clk); penable = 1;
        e = use_k ? k : m_read(a);
        chk(prdata === e, tag, 64'(prdata), 64'(e));
        @(negedge clk); psel = 0; penable = 0;
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            finished = 1;
            miscompares++;
            $display("FAIL watchdog expired actual=running expected=done");
            $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
            $finish;
        end
    end

    initial begin
        idle(5);
        chk(rail_dpd === '0, "R1 outputs in reset", 64'(rail_dpd), 64'd0);
        rst_n = 1;
        rd(12'h1BC, "R1 status0 after reset", 1, 32'h0);
        rd(12'h1C4, "R1 status1 after reset", 1, 32'h0);
        rd(12'h1B8, "R1 request0 idle", 1, 32'h0);
        rd(12'h1C0, "R1 request1 idle", 1, 32'h0);
        rd(12'h020, "R1 sampling off", 1, 32'h0);

        wr(12'h1C8, 32'd5);
        rd(12'h1C8, "R2 count readback", 1, 32'd5);
        wr(12'h020, 32'd1);
        rd(12'h020, "R2 sample readback", 1, 32'd1);

        wr(12'h1B8, 32'h8000_0F0F);
        rd(12'h1BC, "R4 status not yet settled", 1, 32'h0);
        idle(8);
        rd(12'h1BC, "R4 enter settled bank0", 1, 32'h0000_0F0F);
        wr(12'h1C0, 32'h8000_0003);
        idle(8);
        rd(12'h1C4, "R3 bank1 rails 30/31", 1, 32'h0000_0003);
        chk(rail_dpd === 60'h0_C000_0F0F, "R3 output vector", 64'(rail_dpd), 64'h0_C000_0F0F);

        wr(12'h1B8, 32'h4000_0003);
        idle(8);
        rd(12'h1BC, "R4 leave clears selected R5 others kept", 1, 32'h0000_0F0C);

        wr(12'h1B8, 32'h0000_FFFF);
        idle(8);
        rd(12'h1BC, "R5 idle code no effect", 1, 32'h0000_0F0C);
        rd(12'h1B8, "R2 request readback", 1, 32'h0000_FFFF);
        wr(12'h1B8, 32'hC000_FFFF);
        idle(8);
        rd(12'h1BC, "R5 reserved code no effect", 1, 32'h0000_0F0C);
        rd(12'h1BC, "R8 status top bits zero", 1, 32'h0000_0F0C);

        wr(12'h020, 32'd0);
        wr(12'h1B8, 32'h8000_00F0);
        idle(10);
        rd(12'h1BC, "R6 disabled request ignored", 1, 32'h0000_0F0C);
        chk(rail_dpd === 60'h0_C000_0F0C, "R6 outputs unchanged", 64'(rail_dpd), 64'h0_C000_0F0C);
        wr(12'h020, 32'd1);

        wr(12'h1C8, 32'd0);
        wr(12'h1C0, 32'h8010_0000);
        rd(12'h1C4, "R10 zero count settles in one cycle", 1, 32'h0010_0003);

        wr(12'h1C8, 32'd20);
        wr(12'h1B8, 32'h8000_1000);
        wr(12'h1B8, 32'h8000_2000);
        wr(12'h1B8, 32'h8000_4000);
        idle(14);
        rd(12'h1BC, "R7 first done, parked pending", 0, 32'h0);
        idle(60);
        rd(12'h1BC, "R7 parked applied, third dropped", 1, 32'h0000_3F0C);

        stuck[5] = 1'b1;
        wr(12'h1B8, 32'h8000_0020);
        idle(25);
        rd(12'h1BC, "R9 stuck rail status follows ack", 1, 32'h0000_3F0C);
        chk(rail_dpd[5] === 1'b1, "R9 command still driven", 64'(rail_dpd[5]), 64'd1);
        stuck = '0;

        // completion and new request on the same edge (R7)
        for (int t = 0; t < 5; t++) begin
            wr(12'h1C8, 32'(t));
            wr(12'h1C0, 32'h8000_0100);
            wr(12'h1C0, 32'h4000_0100);
            wr(12'h1C0, 32'h8000_0200);
            idle(3);
            rd(12'h1C4, "R7 same-edge request", 0, 32'h0);
            idle(12);
            rd(12'h1C4, "R7 same-edge settled", 0, 32'h0);
        end

        finished = 1;
        $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
        $finish;
    end
endmodule